// File: doc/BRIEF.md
# Serial Flash Status Register Controller

This block is the serial-slave front end and status logic of a serial NOR flash device. It samples the chip-select, serial-clock, data-in and write-protect pins into the system clock domain. It collects an 8-bit command and, for a status write, one data byte, sent most significant bit first. It holds the status byte. That byte combines four protection bits, a write-lock bit, a write-enable latch and a busy flag.

A status write takes effect only when three things hold. A write-enable command must have armed the latch first. Chip select must rise exactly on the 16-bit frame boundary. The hardware lock must not be active. An accepted write starts a self-timed busy period, counted in system clocks. While it runs, the busy flag is set and the status byte can still be polled with the read command. When the period ends, the busy flag drops and the write-enable latch clears.

Top module: `spi_status_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00: lock bit 7 clear, protect bits 5..2 clear, latch bit 1 clear, busy bit 0 clear.
- R2: `miso_o` is 0 while chip select is high. After opcode 0x05, the status byte is shifted out MSB first on falling serial-clock edges, and it is reloaded with live contents at every further byte boundary of the same frame.
- R3: A frame of exactly 8 bits carrying opcode 0x06 sets the write-enable latch (status bit 1).
- R4: A 16-bit frame of opcode 0x01 plus a data byte, with the latch set, loads data bits 7 and 5..2 into the status byte. Bits 6, 1 and 0 are not taken from the data, and bit 6 always reads 0.
- R5: A status write received while the latch is clear changes nothing.
- R6: A status write frame is executed only when chip select rises after exactly 16 bits. A frame of 15 or 17 bits changes nothing.
- R7: An accepted status write sets the busy bit (bit 0) for WR_CYCLES system clocks. After that the busy bit reads 0 and the latch is clear.
- R8: While the busy bit is 1, a further status write is ignored and the status byte remains readable.
- R9: When bit 7 is 1 and `wp_n_i` is low, a status write is not executed. With `wp_n_i` high, it is executed.
- R10: A write-enable opcode in a frame of 7 or 9 bits does not set the latch.
- R11: A frame with an opcode other than 0x06, 0x01 or 0x05 leaves the status byte unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Serial chip select, active low |
| sclk_i | input | 1 | Serial clock from the host |
| mosi_i | input | 1 | Serial data into the block |
| wp_n_i | input | 1 | Write-protect pin, active low |
| miso_o | output | 1 | Serial data out of the block |

## Verification
The hardest state to reach is a status write arriving while a self-timed cycle is already running. Only a correctly armed and framed write can put the block there, and the window closes after WR_CYCLES clocks. The bench sets the write period well beyond the length of one read frame. It then issues write-enable, an accepted write and a second write back to back, and reads the status before and after the period expires. A single long read frame that spans the whole period shows the busy bit dropping between bytes, which confirms that the status is reloaded live at each byte boundary.

// File: rtl/spi_sr_pkg.sv
package spi_sr_pkg;
    localparam logic [7:0] OPC_WR_EN    = 8'h06;
    localparam logic [7:0] OPC_SR_WRITE = 8'h01;
    localparam logic [7:0] OPC_SR_READ  = 8'h05;
    // status bits a write may change: lock bit 7 and protect bits 5..2
    localparam logic [7:0] SR_WRITABLE  = 8'hBC;
    localparam int         SR_LOCK_BIT  = 7;

    typedef struct packed {
        logic       cs_prev;
        logic       sclk_prev;
        logic [2:0] bit_idx;
        logic [1:0] byte_cnt;
        logic [7:0] rx_sh;
        logic [7:0] opcode;
        logic [7:0] tx_sh;
        logic       miso;
    } frame_st_t;

    typedef struct packed {
        logic [7:0] prot;
        logic       wel;
    } reg_st_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int               WIDTH   = 4,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
        else        pipe_q <= pipe_d;
    end

    assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/spi_frame.sv
module spi_frame
    import spi_sr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n_s,
    input  logic       sclk_s,
    input  logic       mosi_s,
    input  logic [7:0] status_i,
    output logic       wren_o,
    output logic       wrsr_o,
    output logic [7:0] wr_data_o,
    output logic       miso_o
);
    frame_st_t st_d, st_q;
    logic cs_low, cs_fall, cs_rise, sclk_rise, sclk_fall;

    assign cs_low    = ~cs_n_s;
    assign cs_fall   = ~cs_n_s & st_q.cs_prev;
    assign cs_rise   = cs_n_s & ~st_q.cs_prev;
    assign sclk_rise = sclk_s & ~st_q.sclk_prev;
    assign sclk_fall = ~sclk_s & st_q.sclk_prev;

    always_comb begin
        st_d           = st_q;
        st_d.cs_prev   = cs_n_s;
        st_d.sclk_prev = sclk_s;
        wren_o         = 1'b0;
        wrsr_o         = 1'b0;
        if (cs_fall) begin
            st_d.bit_idx  = '0;
            st_d.byte_cnt = '0;
            st_d.opcode   = '0;
        end else if (cs_low) begin
            if (sclk_rise) begin
                st_d.rx_sh   = {st_q.rx_sh[6:0], mosi_s};
                st_d.bit_idx = st_q.bit_idx + 3'd1;
                if (st_q.bit_idx == 3'd7) begin
                    if (st_q.byte_cnt != 2'd3) st_d.byte_cnt = st_q.byte_cnt + 2'd1;
                    if (st_q.byte_cnt == 2'd0) st_d.opcode = {st_q.rx_sh[6:0], mosi_s};
                end
            end
            if (sclk_fall && st_q.opcode == OPC_SR_READ && st_q.byte_cnt != 2'd0) begin
                if (st_q.bit_idx == 3'd0) begin
                    st_d.miso  = status_i[7];
                    st_d.tx_sh = {status_i[6:0], 1'b0};
                end else begin
                    st_d.miso  = st_q.tx_sh[7];
                    st_d.tx_sh = {st_q.tx_sh[6:0], 1'b0};
                end
            end
        end
        if (!cs_low) st_d.miso = 1'b0;
        if (cs_rise && st_q.bit_idx == 3'd0) begin
            wren_o = (st_q.byte_cnt == 2'd1) && (st_q.opcode == OPC_WR_EN);
            wrsr_o = (st_q.byte_cnt == 2'd2) && (st_q.opcode == OPC_SR_WRITE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.cs_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_data_o = st_q.rx_sh;
    assign miso_o    = st_q.miso;
endmodule

// File: rtl/sr_timer.sv
module sr_timer #(
    parameter int CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);
    localparam int            CW   = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_st_t;

    tmr_st_t t_d, t_q;

    assign done_o = t_q.busy && (t_q.cnt == '0);
    assign busy_o = t_q.busy;

    always_comb begin
        t_d = t_q;
        if (start_i) begin
            t_d.busy = 1'b1;
            t_d.cnt  = LOAD;
        end else if (done_o) begin
            t_d.busy = 1'b0;
        end else if (t_q.busy) begin
            t_d.cnt = t_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end
endmodule

// File: rtl/spi_status_ctrl.sv
module spi_status_ctrl
    import spi_sr_pkg::*;
#(
    parameter int WR_CYCLES   = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    input  logic sclk_i,
    input  logic mosi_i,
    input  logic wp_n_i,
    output logic miso_o
);
    localparam int PIN_W = 4;

    logic [PIN_W-1:0] pins_s;
    logic       wren_req, wrsr_req, wip_busy, tmr_done, start, hpm, wel_w;
    logic [7:0] wr_data, status, prot_w;
    reg_st_t    reg_d, reg_q;

    spi_sync #(
        .WIDTH  (PIN_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(4'b1001)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({wp_n_i, mosi_i, sclk_i, cs_n_i}),
        .sync_o (pins_s)
    );

    spi_frame u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_s   (pins_s[0]),
        .sclk_s   (pins_s[1]),
        .mosi_s   (pins_s[2]),
        .status_i (status),
        .wren_o   (wren_req),
        .wrsr_o   (wrsr_req),
        .wr_data_o(wr_data),
        .miso_o   (miso_o)
    );

    sr_timer #(.CYCLES(WR_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start),
        .busy_o (wip_busy),
        .done_o (tmr_done)
    );

    assign hpm    = reg_q.prot[SR_LOCK_BIT] & ~pins_s[3];
    assign status = (reg_q.prot & SR_WRITABLE) | {6'b0, reg_q.wel, wip_busy};
    assign wel_w  = reg_q.wel;
    assign prot_w = reg_q.prot;

    always_comb begin
        reg_d = reg_q;
        start = 1'b0;
        if (tmr_done) reg_d.wel = 1'b0;
        if (!wip_busy) begin
            if (wren_req) reg_d.wel = 1'b1;
            if (wrsr_req && reg_q.wel && !hpm) begin
                reg_d.prot = wr_data & SR_WRITABLE;
                start      = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end
endmodule

// File: rtl/spi_status_chk.sv
module spi_status_chk #(
    parameter int WR_CYCLES = 2000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       wel,
    input logic [7:0] prot,
    input logic       hpm
);
    int run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_q <= 0;
        else if (busy) run_q <= run_q + 1;
        else           run_q <= 0;
    end

    // R7
    wip_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> run_q == WR_CYCLES);

    // R7
    wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel);

    // R5
    wip_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wel));

    // R9
    hpm_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(hpm));

    // R8
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(prot));
endmodule

bind spi_status_ctrl spi_status_chk #(.WR_CYCLES(WR_CYCLES)) chk_i (
    .clk  (clk),
    .rst_n(rst_n),
    .busy (wip_busy),
    .wel  (wel_w),
    .prot (prot_w),
    .hpm  (hpm)
);

// File: tb/spi_status_ctrl_tb.sv
module spi_status_ctrl_tb_top;
    localparam int WR_CYC = 2000;
    localparam int HALF   = 8;

    typedef struct packed {
        logic [31:0] frame;
        logic [7:0]  nbits;
        logic        wp_n;
        logic [7:0]  exp_now;
        logic [7:0]  exp_after;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{32'h01FC, 8'd16, 1'b1, 8'h00, 8'h00, 8'd5},  // R5 write without latch
        '{32'h0006, 8'd8,  1'b1, 8'h02, 8'h02, 8'd3},  // R3 write enable
        '{32'h01FF, 8'd16, 1'b1, 8'hBF, 8'hBC, 8'd4},  // R4 masked write, R7 busy then clear
        '{32'h0003, 8'd7,  1'b1, 8'hBC, 8'hBC, 8'd10}, // R10 seven bits
        '{32'h000C, 8'd9,  1'b1, 8'hBC, 8'hBC, 8'd10}, // R10 nine bits
        '{32'h009F, 8'd8,  1'b1, 8'hBC, 8'hBC, 8'd11}, // R11 unknown opcode
        '{32'h0006, 8'd8,  1'b1, 8'hBE, 8'hBE, 8'd3},  // R3
        '{32'h0100, 8'd16, 1'b0, 8'hBE, 8'hBE, 8'd9},  // R9 locked, pin low
        '{32'h0141, 8'd16, 1'b1, 8'h03, 8'h00, 8'd9},  // R9 pin high, R4 bits 6,0 ignored
        '{32'h0006, 8'd8,  1'b1, 8'h02, 8'h02, 8'd3},  // R3
        '{32'h0092, 8'd15, 1'b1, 8'h02, 8'h02, 8'd6},  // R6 fifteen bits
        '{32'h0330, 8'd17, 1'b1, 8'h02, 8'h02, 8'd6},  // R6 seventeen bits
        '{32'h0198, 8'd16, 1'b1, 8'h9B, 8'h98, 8'd6}   // R6 exact sixteen bits
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0, wp_n = 1'b1;
    logic miso;
    int   checks = 0, errors = 0;

    always #5 clk = ~clk;

    spi_status_ctrl #(.WR_CYCLES(WR_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk),
        .mosi_i(mosi), .wp_n_i(wp_n), .miso_o(miso)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_bit(input logic b, output logic r);
        mosi = b;
        tick(HALF);
        r    = miso;
        sclk = 1'b1;
        tick(HALF);
        sclk = 1'b0;
    endtask

    task automatic cs_on;
        cs_n = 1'b0;
        tick(HALF);
    endtask

    task automatic cs_off;
        tick(HALF);
        cs_n = 1'b1;
        tick(2 * HALF);
    endtask

    task automatic spi_xfer(input logic [31:0] data, input int nbits, output logic [31:0] rx);
        logic r;
        rx = '0;
        cs_on();
        for (int i = nbits - 1; i >= 0; i--) begin
            spi_bit(data[i], r);
            rx = {rx[30:0], r};
        end
        cs_off();
    endtask

    task automatic read_status(output logic [7:0] st);
        logic [31:0] rx;
        spi_xfer(32'h0500, 16, rx);
        st = rx[7:0];
    endtask

    task automatic poll_long(input int nbytes, output logic [7:0] first, output logic [7:0] last);
        logic r;
        logic [7:0] b;
        cs_on();
        for (int i = 7; i >= 0; i--) spi_bit(OPC_BIT(i), r);
        for (int k = 0; k < nbytes; k++) begin
            b = '0;
            for (int i = 0; i < 8; i++) begin
                spi_bit(1'b0, r);
                b = {b[6:0], r};
            end
            if (k == 0) first = b;
            last = b;
        end
        cs_off();
    endtask

    function automatic logic OPC_BIT(input int i);
        logic [7:0] op = 8'h05;
        return op[i];
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0]  st, f, l;
        logic [31:0] rx;
        tick(4);
        rst_n = 1'b1;
        tick(4);

        // R2 idle output, R1 reset value
        check("R2 idle miso", {7'b0, miso}, 8'h00);
        read_status(st);
        check("R1 reset status", st, 8'h00);

        for (int v = 0; v < NV; v++) begin
            wp_n = VECS[v].wp_n;
            spi_xfer(VECS[v].frame, int'(VECS[v].nbits), rx);
            read_status(st);
            check($sformatf("R%0d vec %0d now", VECS[v].req, v), st, VECS[v].exp_now);
            tick(WR_CYC + 100);
            read_status(st);
            check($sformatf("R%0d vec %0d after", VECS[v].req, v), st, VECS[v].exp_after);
        end
        wp_n = 1'b1;

        // R8: second write during busy is ignored, status still readable
        spi_xfer(32'h06, 8, rx);
        spi_xfer(32'h010C, 16, rx);
        spi_xfer(32'h0130, 16, rx);
        read_status(st);
        check("R8 read while busy", st, 8'h0F);
        tick(WR_CYC + 100);
        read_status(st);
        check("R8 write during busy ignored", st, 8'h0C);

        // R2 live reload across a long read, R7 busy drops and latch clears
        spi_xfer(32'h06, 8, rx);
        spi_xfer(32'h0124, 16, rx);
        poll_long(24, f, l);
        check("R2 first polled byte", f, 8'h27);
        check("R7 last polled byte", l, 8'h24);
        check("R2 idle miso after read", {7'b0, miso}, 8'h00);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule